// File: doc/BRIEF.md
# Switchable Program-ROM Bank Mapper

This block sits between a CPU and an external program ROM split into 8 KiB banks. The CPU's upper 32 KiB (addresses 0x8000 to 0xFFFF) is seen as four 8 KiB windows. Two of them take their bank numbers from registers loaded by software. The other two are pinned to the last and second-to-last bank of the ROM. The block turns each CPU address into a ROM byte address, made of the bank number above the 13-bit offset inside the window.

Software loads the bank registers through a two-step protocol at 0x8000 to 0x9FFF. A write to an even address picks which register the next data write targets, and it also carries a layout bit. A write to an odd address stores the byte into the picked register. Only the two program-bank registers, index 6 and index 7, affect this block. The other register indices, the mirroring and interrupt addresses all decode cleanly and change nothing here. A control register at odd addresses in 0x A000 to 0xBFFF enables an optional 8 KiB work RAM at 0x6000 to 0x7FFF and can protect it from writes.

Bank numbers wrap modulo the actual ROM bank count, which is an input and does not have to be a power of two.

Top module: `prg_bank_mapper`

## Requirements
- R1: `prg_addr[12:0]` always equals `cpu_addr[12:0]`, and `prg_addr[18:13]` holds the selected 8 KiB bank.
- R2: For any `cpu_addr` in 0xE000 to 0xFFFF, the bank is `bank_count-1`, whatever has been written.
- R3: A write with `cpu_addr[15:13]=3'b100` and `cpu_addr[0]=0` stores data bits [2:0] as the register index and data bit 6 as the layout bit. The same range with `cpu_addr[0]=1` loads the data byte into the indexed register.
- R4: With layout bit 0, the window at 0x8000 to 0x9FFF uses the index-6 value and the window at 0xC000 to 0xDFFF uses `bank_count-2`.
- R5: With layout bit 1, the window at 0x8000 to 0x9FFF uses `bank_count-2` and the window at 0xC000 to 0xDFFF uses the index-6 value.
- R6: The window at 0xA000 to 0xBFFF uses the index-7 value under either layout.
- R7: A stored 8-bit bank value maps to that value modulo `bank_count`, for `bank_count` from 2 to 64.
- R8: The following writes leave the mapping unchanged: data writes while the index is 0 to 5, writes at even addresses in 0xA000 to 0xBFFF, and writes anywhere in 0xC000 to 0xFFFF.
- R9: A write with `cpu_addr[15:13]=3'b101` and `cpu_addr[0]=1` sets the RAM enable from data bit 7 and the write protect from data bit 6. `wram_ce` is high when `cpu_addr` is in 0x6000 to 0x7FFF and RAM is enabled. `wram_we` is `wram_ce` and `cpu_we` with protect clear.
- R10: After reset the index-6 value is 0, the index-7 value is 1, the layout bit is 0, and RAM is disabled and unprotected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, one cycle per write |
| bank_count | input | 7 | Number of 8 KiB ROM banks (2 to 64) |
| prg_addr | output | 19 | ROM byte address |
| wram_ce | output | 1 | Work RAM chip enable |
| wram_we | output | 1 | Work RAM write enable |

## Verification
A wrong index, layout bit or bank value shows at `prg_addr` on the next read of the affected window, which is the cycle after the write's clock edge. A wrong wrap shows only when the stored value is at least `bank_count`, so the bench stores values up to 0xFF and uses bank counts that are not powers of two. A lost RAM enable or protect bit shows at `wram_ce` or `wram_we` on the very next access to 0x6000 to 0x7FFF. A decode slip that lets an ignored write land shows as a changed window bank at the following read.

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper #(
  parameter int BANK_W = 6,
  localparam int AW = BANK_W + 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   cpu_addr,
  input  logic [7:0]    cpu_wdata,
  input  logic          cpu_we,
  input  logic [BANK_W:0] bank_count,
  output logic [AW-1:0] prg_addr,
  output logic          wram_ce,
  output logic          wram_we
);
  logic [2:0] idx;
  logic       swap;
  logic [7:0] win_a, win_b;
  logic       ram_on, ram_ro;

  wire in_pair  = cpu_addr[15:13] == 3'b100;
  wire wr_index = cpu_we && in_pair && !cpu_addr[0];
  wire wr_value = cpu_we && in_pair &&  cpu_addr[0];
  wire wr_ramct = cpu_we && cpu_addr[15:13] == 3'b101 && cpu_addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= 3'd0;
      swap   <= 1'b0;
      win_a  <= 8'd0;
      win_b  <= 8'd1;
      ram_on <= 1'b0;
      ram_ro <= 1'b0;
    end else begin
      if (wr_index) begin
        idx  <= cpu_wdata[2:0];
        swap <= cpu_wdata[6];
      end
      if (wr_value && idx == 3'd6) win_a <= cpu_wdata;
      if (wr_value && idx == 3'd7) win_b <= cpu_wdata;
      if (wr_ramct) begin
        ram_on <= cpu_wdata[7];
        ram_ro <= cpu_wdata[6];
      end
    end
  end

  function automatic logic [BANK_W-1:0] wrap(input logic [7:0] v, input logic [BANK_W:0] n);
    logic [8:0] r;
    r = (n == '0) ? 9'd0 : (9'(v) % 9'(n));
    return r[BANK_W-1:0];
  endfunction

  logic [BANK_W:0]   last_w, penult_w;
  logic [BANK_W-1:0] bank;

  assign last_w   = bank_count - 1'b1;
  assign penult_w = bank_count - 2'd2;

  always_comb begin
    case (cpu_addr[14:13])
      2'd0:    bank = swap ? penult_w[BANK_W-1:0] : wrap(win_a, bank_count);
      2'd1:    bank = wrap(win_b, bank_count);
      2'd2:    bank = swap ? wrap(win_a, bank_count) : penult_w[BANK_W-1:0];
      default: bank = last_w[BANK_W-1:0];
    endcase
  end

  assign prg_addr = {bank, cpu_addr[12:0]};
  assign wram_ce  = ram_on && cpu_addr[15:13] == 3'b011;
  assign wram_we  = wram_ce && cpu_we && !ram_ro;
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
  parameter int BANK_W = 6,
  localparam int AW = BANK_W + 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   cpu_addr,
  input logic          cpu_we,
  input logic [BANK_W:0] bank_count,
  input logic [AW-1:0] prg_addr,
  input logic          wram_ce,
  input logic          wram_we
);
  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15] |-> prg_addr[12:0] == cpu_addr[12:0]);
  // R2
  top_window_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111 && bank_count >= 2) |->
      {1'b0, prg_addr[AW-1:13]} == bank_count - 1'b1);
  // R7
  bank_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15] && bank_count >= 2) |-> {1'b0, prg_addr[AW-1:13]} < bank_count);
  // R8
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cpu_we) && $stable(cpu_addr) && $stable(bank_count)) |-> $stable(prg_addr));
  // R9
  ram_we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wram_we |-> (wram_ce && cpu_we));
  // R9
  ram_ce_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wram_ce |-> cpu_addr[15:13] == 3'b011);
endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
  .bank_count(bank_count), .prg_addr(prg_addr), .wram_ce(wram_ce), .wram_we(wram_we)
);

// File: tb/tb_prg_bank_mapper.sv
module tb_prg_bank_mapper;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic        cpu_we = 0;
  logic [6:0]  bank_count = 7'd6;
  logic [18:0] prg_addr;
  logic        wram_ce, wram_we;

  prg_bank_mapper dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int m_idx, m_a, m_b;
  bit m_swap, m_on, m_ro;

  function automatic int exp_bank(input logic [15:0] a);
    int c;
    c = bank_count;
    case (a[14:13])
      2'd0: return m_swap ? c - 2 : m_a % c;
      2'd1: return m_b % c;
      2'd2: return m_swap ? m_a % c : c - 2;
      default: return c - 1;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, input string req);
    @(negedge clk);
    cpu_addr = a; cpu_we = 0;
    #2;
    if (a[15]) begin
      check(req, int'(prg_addr[12:0]), int'(a[12:0]));
      check(req, int'(prg_addr[18:13]), exp_bank(a));
    end
    check({req, " R9 ce"}, int'(wram_ce), int'(m_on && a[15:13] == 3'b011));
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1;
    #2;
    if (a[15:13] == 3'b011)
      check("R9 we", int'(wram_we), int'(m_on && !m_ro));
    @(posedge clk);
    if (a[15:13] == 3'b100 && !a[0]) begin m_idx = d[2:0]; m_swap = d[6]; end
    if (a[15:13] == 3'b100 && a[0] && m_idx == 6) m_a = d;
    if (a[15:13] == 3'b100 && a[0] && m_idx == 7) m_b = d;
    if (a[15:13] == 3'b101 && a[0]) begin m_on = d[7]; m_ro = d[6]; end
    #1 cpu_we = 0;
  endtask

  task automatic rd_all(input string req);
    rd(16'h8123, req); rd(16'hA456, req); rd(16'hC789, req); rd(16'hFFFF, req);
  endtask

  initial begin
    #(100000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_idx = 0; m_swap = 0; m_a = 0; m_b = 1; m_on = 0; m_ro = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10 reset state
    rd_all("R10");
    rd(16'h6000, "R10");
    // R4 / R3 / R7: index 6, default layout, wrap 0xFF % 6 = 3
    wr(16'h8000, 8'h06); wr(16'h8001, 8'hFF);
    rd(16'h8000, "R4 R7"); rd(16'hC000, "R4");
    // R6: index 7
    wr(16'h8000, 8'h07); wr(16'h8001, 8'd4);
    rd(16'hA000, "R6");
    // R5 swapped layout
    wr(16'h8000, 8'h46);
    rd_all("R5");
    // R8 ignored writes
    wr(16'h8000, 8'h42); wr(16'h8001, 8'd9);
    wr(16'hA000, 8'hFF); wr(16'hC000, 8'h00); wr(16'hC001, 8'h11); wr(16'hE001, 8'h01);
    rd_all("R8");
    // R2 last bank with non power-of-two count
    bank_count = 7'd37;
    rd(16'hE000, "R2"); rd(16'hFFFE, "R2");
    // R9 RAM enable / protect
    wr(16'hA001, 8'h80); rd(16'h6000, "R9"); wr(16'h7FFF, 8'h55);
    wr(16'hA001, 8'hC0); wr(16'h6001, 8'h55);
    wr(16'hA001, 8'h00); rd(16'h7000, "R9"); wr(16'h6000, 8'h00);
    // R7 full count
    bank_count = 7'd64;
    wr(16'h8000, 8'h07); wr(16'h8001, 8'hC5);
    rd(16'hA000, "R7");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [15:0] a;
      op = $urandom_range(0, 9);
      a = 16'($urandom);
      if (op == 0) begin
        @(negedge clk);
        bank_count = 7'($urandom_range(2, 64));
      end else if (op < 5) begin
        case ($urandom_range(0, 3))
          0: a[15:13] = 3'b100;
          1: a[15:13] = 3'b101;
          2: a[15:13] = 3'b011;
          default: a[15] = 1'b1;
        endcase
        wr(a, 8'($urandom));
      end else begin
        if ($urandom_range(0, 3) == 0) a[15:13] = 3'b011; else a[15] = 1'b1;
        rd(a, "R1 R4 R5 R6 R7 R9 random");
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule